// File: doc/BRIEF.md
# Sequential-Block Configuration Register Slave

This block is a slave on a two-wire serial bus of the I2C/SMBus kind. It holds a small bank of 8-bit configuration registers whose outputs feed clock-control logic elsewhere on the chip. A host reaches the bank only through block transfers. Every access starts at register 0 and moves upward one register per byte. There is no way to address a single register directly.

In a write transfer, the host sends the device address with the write bit. It then sends two bytes that the slave acknowledges and throws away: a command byte and a count byte. After these come the data bytes, which fill the registers from index 0 upward. In a read transfer, the slave first returns the register count and then the register contents in ascending order. The host may stop after any complete byte.

SCL and SDA are sampled into the system clock domain through a synchroniser. The slave pulls SDA low through an output-enable, and an external pull-up supplies the high level.

Top module: `cfgi2c_slave`

## Requirements
- R1: Only the address bytes 0xD4 (write) and 0xD5 (read) are acknowledged. Both use the 7-bit address 0x6A, MSB first, with the direction in bit 0. After any other address byte the slave leaves SDA released until the next start or stop, so it acknowledges no further bytes and changes no register.
- R2: In a write, the first two bytes after the address are acknowledged, and their values never reach any register.
- R3: In a write, the data bytes load registers 0 to 6 strictly in ascending order, and each one is acknowledged. Data bytes after the seventh are acknowledged and have no effect.
- R4: A stop after any complete data byte leaves the registers already written holding their new values. All other registers keep their previous values.
- R5: In a read, the first byte sent is 7, followed by registers 0 to 6 in order, MSB first. Any byte requested after register 6 reads as 0xFF.
- R6: When the host NACKs a read byte, the slave releases SDA and drives nothing more until the next start or stop.
- R7: A synchronous active-high reset sets register i (bits 8i+7..8i of cfg_regs) to 0xA0 + i and releases SDA.
- R8: A repeated start ends the current transfer and begins a new one with its own address byte. The byte index restarts, so the dummy bytes and register 0 come first again.
- R9: The slave only ever pulls SDA low, and it changes its SDA drive only while SCL is low.
- R10: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. SDA activity while SCL is low is neither and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| cfg_regs | output | 56 | Register bank, register i at bits 8i+7..8i |

## Verification
A corrupted byte index shows up in two ways. It puts a data byte into the wrong register, which is visible on cfg_regs right after the eighth bit of that byte. It also sends the wrong byte during a read, which the host sees within the next byte time. A wrong state after the address phase turns into a missing or spurious acknowledge in the ninth clock of the same byte. A slave that fails to release SDA after a NACK or a stop corrupts the next bits the host reads, so the bench reads extra bits after a NACK. The bench also watches every change of the SDA drive against the level of SCL.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int          CFG_NREGS = 7;
    localparam logic [6:0]  CFG_DEV   = 7'h6A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_ACK,
        ST_SEND,
        ST_HACK,
        ST_HWAIT,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [7:0] cfg_default(input int idx);
        return 8'hA0 + 8'(idx);
    endfunction

endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync
    import cfgi2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [1:0] raw;
    logic [1:0] clean;
    logic [1:0] clean_q;

    assign raw = {scl_i, sda_i};

    for (genvar ch = 0; ch < 2; ch++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[ch]};
        end
        assign clean[ch] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) clean_q <= '1;
        else     clean_q <= clean;
    end

    assign evt.scl   = clean[1];
    assign evt.sda   = clean[0];
    assign evt.rise  = clean[1] & ~clean_q[1];
    assign evt.fall  = ~clean[1] & clean_q[1];
    assign evt.start = clean[1] & clean_q[1] & clean_q[0] & ~clean[0];
    assign evt.stop  = clean[1] & clean_q[1] & ~clean_q[0] & clean[0];

endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank
    import cfgi2c_pkg::*;
#(
    parameter int NUM_REGS = CFG_NREGS,
    parameter int IW       = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] value;
        always_ff @(posedge clk) begin
            if (rst)
                value <= cfg_default(g);
            else if (wr_en && wr_idx == IW'(g))
                value <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = value;
    end

endmodule

// File: rtl/cfgi2c_slave.sv
module cfgi2c_slave
    import cfgi2c_pkg::*;
#(
    parameter int         NUM_REGS    = CFG_NREGS,
    parameter logic [6:0] DEV_ADDR    = CFG_DEV,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    localparam int            IW        = $clog2(NUM_REGS + 3);
    localparam logic [IW-1:0] IDX_SAT   = IW'(NUM_REGS + 2);
    localparam logic [IW-1:0] IDX_DATA0 = IW'(2);

    function automatic logic [NUM_REGS*8-1:0] def_vec();
        logic [NUM_REGS*8-1:0] v;
        for (int i = 0; i < NUM_REGS; i++) v[i*8 +: 8] = cfg_default(i);
        return v;
    endfunction

    bus_evt_t      evt;
    slv_state_e    state;
    logic [3:0]    bcnt;
    logic [7:0]    shreg;
    logic          is_read;
    logic [IW-1:0] bidx;
    logic [IW-1:0] bidx_inc;
    logic          byte_done;
    logic          addr_hit;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    tx_byte;

    cfgi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
    );

    cfgi2c_regbank #(.NUM_REGS(NUM_REGS), .IW(IW)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(shreg), .regs_flat(cfg_regs)
    );

    assign byte_done = (bcnt == 4'd8) && evt.fall;
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign bidx_inc  = (bidx == IDX_SAT) ? bidx : bidx + 1'b1;
    assign wr_en     = (state == ST_WRITE) && byte_done
                       && (bidx >= IDX_DATA0) && (bidx < IDX_SAT);
    assign wr_idx    = bidx - IDX_DATA0;

    // Byte to send for the current read index: count, registers, then filler
    always_comb begin
        tx_byte = 8'hFF;
        if (bidx == '0) tx_byte = 8'(NUM_REGS);
        for (int i = 0; i < NUM_REGS; i++)
            if (bidx == IW'(i + 1)) tx_byte = cfg_regs[i*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bcnt    <= '0;
            shreg   <= '0;
            is_read <= 1'b0;
            bidx    <= '0;
            sda_oe  <= 1'b0;
        end else if (evt.start) begin
            state   <= ST_ADDR;
            bcnt    <= '0;
            bidx    <= '0;
            is_read <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WRITE: begin
                    if (evt.rise && bcnt < 4'd8) begin
                        shreg <= {shreg[6:0], evt.sda};
                        bcnt  <= bcnt + 1'b1;
                    end else if (byte_done) begin
                        if (state == ST_WRITE) begin
                            sda_oe <= 1'b1;
                            bidx   <= bidx_inc;
                            state  <= ST_ACK;
                        end else if (addr_hit) begin
                            sda_oe  <= 1'b1;
                            is_read <= shreg[0];
                            state   <= ST_ACK;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_ACK: begin
                    if (evt.fall) begin
                        bcnt <= '0;
                        if (is_read) begin
                            shreg  <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            state  <= ST_SEND;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WRITE;
                        end
                    end
                end
                ST_SEND: begin
                    if (evt.rise) begin
                        bcnt <= bcnt + 1'b1;
                    end else if (evt.fall) begin
                        if (bcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            bidx   <= bidx_inc;
                            state  <= ST_HACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (evt.rise) state <= evt.sda ? ST_IGNORE : ST_HWAIT;
                end
                ST_HWAIT: begin
                    if (evt.fall) begin
                        bcnt   <= '0;
                        shreg  <= tx_byte;
                        sda_oe <= ~tx_byte[7];
                        state  <= ST_SEND;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!$past(evt.scl) || $past(evt.start) || $past(evt.stop)));

    assert_ignore_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    assert_write_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < IW'(NUM_REGS)));

    assert_stop_release_R6: assert property (@(posedge clk) disable iff (rst)
        $past(evt.stop) |-> !sda_oe);

    assert_reset_defaults_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_regs == def_vec()));

    assert_start_restart_R8: assert property (@(posedge clk) disable iff (rst)
        $past(evt.start) |-> (state == ST_ADDR && bcnt == 4'd0 && bidx == '0));

endmodule

// File: tb/cfgi2c_slave_test.sv
module cfgi2c_slave_test;
    localparam int N = 7;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic [N*8-1:0] cfg_regs;
    wire  sda_bus = sda_h & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int r9_viol = 0;
    logic done = 1'b0;
    logic [7:0] model [N];

    always #4 clk = ~clk;

    cfgi2c_slave uut (
        .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_bus),
        .sda_oe(sda_oe), .cfg_regs(cfg_regs)
    );

    // R9: any change of the drive while SCL is high is a violation
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe !== oe_prev && scl_h) r9_viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N*8-1:0] model_vec();
        logic [N*8-1:0] v;
        for (int i = 0; i < N; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic q(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_h = 1'b1; q(); scl_h = 1'b1; q(); sda_h = 1'b0; q(); scl_h = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; q(); scl_h = 1'b1; q(); sda_h = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; q(); scl_h = 1'b1; q(); q(); scl_h = 1'b0; q();
        end
        sda_h = 1'b1; q(); scl_h = 1'b1; q(); ack = ~sda_bus; q(); scl_h = 1'b0; q();
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q(); scl_h = 1'b1; q(); b[i] = sda_bus; q(); scl_h = 1'b0;
        end
        q(); sda_h = ~host_ack; q(); scl_h = 1'b1; q(); q(); scl_h = 1'b0; q(); sda_h = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int n, input int k);
        return 8'((n * 53 + k * 29 + 7) & 8'hFF);
    endfunction

    task automatic wr_txn(input int n, input int seed);
        logic a;
        bus_start();
        send_byte(8'hD4, a); chk("R1 write address ack", a, 1'b1);
        send_byte(8'h5A, a); chk("R2 command byte ack", a, 1'b1);
        send_byte(8'h03, a); chk("R2 count byte ack", a, 1'b1);
        for (int k = 0; k < n; k++) begin
            send_byte(pat(seed, k), a); chk("R3 data byte ack", a, 1'b1);
            if (k < N) model[k] = pat(seed, k);
        end
        bus_stop();
        chk("R4 registers after stop", cfg_regs, model_vec());
    endtask

    task automatic rd_all();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD5, a); chk("R1 read address ack", a, 1'b1);
        recv_byte(1'b1, b); chk("R5 count byte", b, 8'd7);
        for (int k = 0; k < N; k++) begin
            recv_byte(k != N - 1, b); chk("R5 register byte", b, model[k]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        for (int i = 0; i < N; i++) model[i] = 8'hA0 + 8'(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 reset defaults", cfg_regs, model_vec());
        chk("R7 SDA released at reset", sda_oe, 1'b0);
        rd_all();

        // R3 R4: stop after every possible number of data bytes
        for (int n = 0; n <= N; n++) begin
            wr_txn(n, n + 1);
            rd_all();
        end

        // R3: bytes past the last register acknowledged, ignored
        wr_txn(N + 2, 40);

        // R1: sweep of write-direction addresses
        for (int ad = 0; ad < 256; ad += 2) begin
            bus_start();
            send_byte(8'(ad), a);
            chk("R1 address sweep ack", a, (ad == 8'hD4));
            bus_stop();
        end
        bus_start();
        send_byte(8'hA6, a); chk("R1 foreign address nack", a, 1'b0);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'h11 * 8'(k), a); chk("R1 no ack after foreign address", a, 1'b0);
        end
        bus_stop();
        chk("R1 registers untouched", cfg_regs, model_vec());
        bus_start();
        send_byte(8'hD7, a); chk("R1 foreign read address nack", a, 1'b0);
        recv_byte(1'b0, b); chk("R1 bus released", b, 8'hFF);
        bus_stop();

        // R6: NACK after m bytes, then slave must stay off the bus
        for (int m = 0; m <= N + 2; m++) begin
            bus_start();
            send_byte(8'hD5, a);
            for (int k = 0; k <= m; k++) begin
                recv_byte(k != m, b);
                if (k == 0) chk("R5 count", b, 8'd7);
                else if (k <= N) chk("R5 data in order", b, model[k-1]);
                else chk("R5 filler past end", b, 8'hFF);
            end
            recv_byte(1'b0, b); chk("R6 released after NACK", b, 8'hFF);
            bus_stop();
        end

        // R8: repeated start restarts the byte index
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h3C, a); send_byte(8'hC3, a);
        bus_start();
        send_byte(8'hD4, a); chk("R8 address after repeated start", a, 1'b1);
        send_byte(8'h77, a); send_byte(8'h66, a);
        send_byte(8'h5E, a);
        bus_stop();
        model[0] = 8'h5E; model[1] = 8'hC3;
        chk("R8 index restarted", cfg_regs, model_vec());
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h01, a);
        bus_start();
        send_byte(8'hD5, a); chk("R8 read after repeated start", a, 1'b1);
        recv_byte(1'b1, b); chk("R8 count first", b, 8'd7);
        recv_byte(1'b0, b); chk("R8 register 0 next", b, model[0]);
        bus_stop();

        // R10: SDA toggling while SCL is low is neither start nor stop
        bus_start();
        send_byte(8'hD4, a); send_byte(8'h00, a); send_byte(8'h00, a);
        sda_h = 1'b0; q(); sda_h = 1'b1; q(); sda_h = 1'b0; q();
        send_byte(8'h9D, a); chk("R10 byte after SDA glitch acked", a, 1'b1);
        send_byte(8'h4B, a);
        bus_stop();
        model[0] = 8'h9D; model[1] = 8'h4B;
        chk("R10 registers after glitch", cfg_regs, model_vec());

        chk("R9 drive changes only with SCL low", r9_viol, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule